// File: doc/BRIEF.md
# Router Input Virtual-Channel Controller

This block manages one input port of a packet router that carries several virtual channels. Each arriving flit names the virtual channel it belongs to and carries head and tail markers. The flit is written into that channel's private buffer. A small per-channel state machine then takes each packet through its lifecycle. When a head flit reaches the front of an idle channel, the channel asks for a route. It waits a programmable number of cycles while the route is computed, then asks for an output virtual channel. Once a grant arrives it is active and forwards flits to the switch until the tail leaves.

The route computation, the allocators and the crossbar sit outside the block. Toward them the block offers per-channel request strobes, accepts grants that carry an output port and an output virtual channel, and exposes each channel's front flit, state and stored output assignment. The switch stage removes flits with a per-channel pop. Two sticky error flags report protocol faults: a non-head flit at the front of an idle channel, and a write into a full buffer.

Top module: `vc_input_ctrl`

## Requirements
- R1: After reset every channel reads idle, has an empty buffer (front_valid low), drives no route or allocation request, and both error flags are low.
- R2: A flit with in_valid high is stored at the next clock edge in the buffer of channel in_vc, and flits leave each buffer in arrival order. The front flit (data, head, tail) appears on that channel's slice of front_data, front_head and front_tail. A pop removes the front flit only while the channel is active; a pop in any other state leaves the front flit in place.
- R3: An idle channel whose front flit is a head flit drives its route_req bit high in that cycle and reads routing after the next edge. The head flit stays in the buffer.
- R4: An idle channel whose front flit is not a head flit sets err_nonhead at the next edge and discards that flit, and the channel stays idle.
- R5: A channel stays in routing for exactly cfg_route_dly + 1 cycles and then reads VC-allocation.
- R6: In VC-allocation, va_req for the channel is high from the (cfg_alloc_dly + 1)-th cycle in that state onward, and low before it.
- R7: A grant (grant_valid high, grant_vc naming a channel whose va_req is high) makes that channel active at the next edge. The channel then presents grant_port on its out_port slice and grant_ovc on its out_ovc slice. A grant to a channel whose va_req is low is ignored.
- R8: When a popped front flit of an active channel is a tail flit, the channel reads idle after that edge.
- R9: A write into a channel whose buffer already holds BUF_DEPTH flits is discarded and sets err_overflow. Both error flags stay set until reset.
- R10: vc_state carries channel v in bits [2v+1:2v], encoded idle = 0, routing = 1, VC-allocation = 2, active = 3. Channel v uses bits [v*FLIT_W +: FLIT_W] of front_data, [v*PORT_W +: PORT_W] of out_port and [v*VC_W +: VC_W] of out_ovc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_route_dly | input | AGE_W | Extra cycles spent in routing |
| cfg_alloc_dly | input | AGE_W | Cycles in VC-allocation before requesting |
| in_valid | input | 1 | Arriving flit present |
| in_vc | input | VC_W | Channel of the arriving flit |
| in_head | input | 1 | Arriving flit is a head flit |
| in_tail | input | 1 | Arriving flit is a tail flit |
| in_data | input | FLIT_W | Arriving flit payload |
| route_req | output | NUM_VC | Per-channel route request strobe |
| va_req | output | NUM_VC | Per-channel output-VC request |
| grant_valid | input | 1 | Allocation grant present |
| grant_vc | input | VC_W | Input channel receiving the grant |
| grant_port | input | PORT_W | Granted output port |
| grant_ovc | input | VC_W | Granted output virtual channel |
| pop | input | NUM_VC | Per-channel front-flit removal from the switch |
| front_valid | output | NUM_VC | Per-channel buffer not empty |
| front_head | output | NUM_VC | Per-channel front flit head marker |
| front_tail | output | NUM_VC | Per-channel front flit tail marker |
| front_data | output | NUM_VC*FLIT_W | Per-channel front flit payload |
| vc_state | output | 2*NUM_VC | Per-channel state code |
| out_port | output | NUM_VC*PORT_W | Per-channel stored output port |
| out_ovc | output | NUM_VC*VC_W | Per-channel stored output VC |
| err_nonhead | output | 1 | Sticky: non-head flit at an idle channel |
| err_overflow | output | 1 | Sticky: write into a full buffer |

## Verification
The hardest situation to reach is a grant that lands exactly at the first cycle of allocation eligibility, together with a pop issued while the channel is still routing. The stimulus drives a premature grant one cycle before va_req rises and a correct one the cycle after, and it holds pop high through routing to show the front flit survives. Overflow needs a buffer filled with no draining. Zero delays let that channel run straight into allocation while writes continue back to back, so the fifth write lands on a full buffer while the state machine is still moving.

// File: rtl/vcc_pkg.sv
// Shared definitions for the input virtual-channel controller.
// Assumes: state codes are visible on the top-level ports and must not change.
package vcc_pkg;

    typedef enum logic [1:0] {
        VC_IDLE   = 2'd0,
        VC_ROUTE  = 2'd1,
        VC_ALLOC  = 2'd2,
        VC_ACTIVE = 2'd3
    } vc_state_e;

endpackage

// File: rtl/vcc_fifo.sv
// Per-channel flit buffer: a circular FIFO of DEPTH entries.
// Assumes: a write into a full buffer is dropped and reported through ovf_evt;
// a read of an empty buffer is ignored. Full is judged before any same-cycle read.
module vcc_fifo #(
    parameter int WIDTH = 18,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full,
    output logic             ovf_evt
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    logic             wr_ok;
    logic             rd_ok;

    // Accept decisions for this cycle.
    always_comb begin
        empty   = (count == '0);
        full    = (count == CNT_W'(DEPTH));
        wr_ok   = wr_en && !full;
        rd_ok   = rd_en && !empty;
        ovf_evt = wr_en && full;
        rd_data = mem[rd_ptr];
    end

    // Storage array, written on accepted writes only.
    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_ok) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (rd_ok) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({wr_ok, rd_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/vcc_fsm.sv
// Per-channel packet lifecycle: idle -> routing -> VC-allocation -> active -> idle.
// Assumes: the front flit inputs describe the buffer head this cycle; the age
// counter holds the number of cycles already spent in the current state and
// saturates at its maximum.
module vcc_fsm
    import vcc_pkg::*;
#(
    parameter int AGE_W  = 4,
    parameter int PORT_W = 3,
    parameter int VC_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AGE_W-1:0]  route_dly,
    input  logic [AGE_W-1:0]  alloc_dly,
    input  logic              front_valid,
    input  logic              front_head,
    input  logic              front_tail,
    input  logic              pop_req,
    input  logic              grant_hit,
    input  logic [PORT_W-1:0] grant_port,
    input  logic [VC_W-1:0]   grant_ovc,
    output vc_state_e         state,
    output logic              route_req,
    output logic              va_req,
    output logic              buf_pop,
    output logic              nonhead_evt,
    output logic [PORT_W-1:0] out_port,
    output logic [VC_W-1:0]   out_ovc
);
    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    vc_state_e        state_nxt;
    logic [AGE_W-1:0] age;

    // Next-state and strobe decode for the current state.
    always_comb begin
        state_nxt   = state;
        route_req   = 1'b0;
        va_req      = 1'b0;
        buf_pop     = 1'b0;
        nonhead_evt = 1'b0;
        case (state)
            VC_IDLE: begin
                if (front_valid) begin
                    if (front_head) begin
                        route_req = 1'b1;
                        state_nxt = VC_ROUTE;
                    end else begin
                        nonhead_evt = 1'b1;
                        buf_pop     = 1'b1;
                    end
                end
            end
            VC_ROUTE: begin
                if (age >= route_dly) begin
                    state_nxt = VC_ALLOC;
                end
            end
            VC_ALLOC: begin
                va_req = (age >= alloc_dly);
                if (va_req && grant_hit) begin
                    state_nxt = VC_ACTIVE;
                end
            end
            VC_ACTIVE: begin
                buf_pop = pop_req && front_valid;
                if (buf_pop && front_tail) begin
                    state_nxt = VC_IDLE;
                end
            end
            default: state_nxt = VC_IDLE;
        endcase
    end

    // State register and saturating age counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= VC_IDLE;
            age   <= '0;
        end else begin
            state <= state_nxt;
            if (state_nxt != state) begin
                age <= '0;
            end else if (age != AGE_MAX) begin
                age <= age + 1'b1;
            end
        end
    end

    // Output assignment captured on an accepted grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_port <= '0;
            out_ovc  <= '0;
        end else if (va_req && grant_hit) begin
            out_port <= grant_port;
            out_ovc  <= grant_ovc;
        end
    end

endmodule

// File: rtl/vcc_lane.sv
// One virtual channel: its flit buffer plus its lifecycle state machine.
// Assumes: wr_en is already decoded for this channel.
module vcc_lane
    import vcc_pkg::*;
#(
    parameter int FLIT_W = 16,
    parameter int DEPTH  = 4,
    parameter int AGE_W  = 4,
    parameter int PORT_W = 3,
    parameter int VC_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AGE_W-1:0]  route_dly,
    input  logic [AGE_W-1:0]  alloc_dly,
    input  logic              wr_en,
    input  logic              wr_head,
    input  logic              wr_tail,
    input  logic [FLIT_W-1:0] wr_data,
    input  logic              pop_req,
    input  logic              grant_hit,
    input  logic [PORT_W-1:0] grant_port,
    input  logic [VC_W-1:0]   grant_ovc,
    output logic              front_valid,
    output logic              front_head,
    output logic              front_tail,
    output logic [FLIT_W-1:0] front_data,
    output vc_state_e         state,
    output logic              route_req,
    output logic              va_req,
    output logic [PORT_W-1:0] out_port,
    output logic [VC_W-1:0]   out_ovc,
    output logic              nonhead_evt,
    output logic              ovf_evt
);
    localparam int ENTRY_W = FLIT_W + 2;

    logic [ENTRY_W-1:0] rd_entry;
    logic               empty;
    logic               full;
    logic               buf_pop;

    vcc_fifo #(
        .WIDTH (ENTRY_W),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data ({wr_head, wr_tail, wr_data}),
        .rd_en   (buf_pop),
        .rd_data (rd_entry),
        .empty   (empty),
        .full    (full),
        .ovf_evt (ovf_evt)
    );

    // Unpack the buffer head into its fields.
    always_comb begin
        front_valid = !empty;
        front_head  = rd_entry[ENTRY_W-1];
        front_tail  = rd_entry[ENTRY_W-2];
        front_data  = rd_entry[FLIT_W-1:0];
    end

    vcc_fsm #(
        .AGE_W  (AGE_W),
        .PORT_W (PORT_W),
        .VC_W   (VC_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .route_dly   (route_dly),
        .alloc_dly   (alloc_dly),
        .front_valid (front_valid),
        .front_head  (front_head),
        .front_tail  (front_tail),
        .pop_req     (pop_req),
        .grant_hit   (grant_hit),
        .grant_port  (grant_port),
        .grant_ovc   (grant_ovc),
        .state       (state),
        .route_req   (route_req),
        .va_req      (va_req),
        .buf_pop     (buf_pop),
        .nonhead_evt (nonhead_evt),
        .out_port    (out_port),
        .out_ovc     (out_ovc)
    );

endmodule

// File: rtl/vc_input_ctrl.sv
// Input-port virtual-channel controller: steers arriving flits into per-channel
// buffers, runs one lifecycle state machine per channel and keeps sticky
// protocol-error flags.
// Assumes: at most one flit arrives per cycle; in_vc and grant_vc values at or
// above NUM_VC select no channel.
module vc_input_ctrl
    import vcc_pkg::*;
#(
    parameter int NUM_VC    = 4,
    parameter int BUF_DEPTH = 4,
    parameter int FLIT_W    = 16,
    parameter int PORT_W    = 3,
    parameter int AGE_W     = 4,
    localparam int VC_W     = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [AGE_W-1:0]         cfg_route_dly,
    input  logic [AGE_W-1:0]         cfg_alloc_dly,
    input  logic                     in_valid,
    input  logic [VC_W-1:0]          in_vc,
    input  logic                     in_head,
    input  logic                     in_tail,
    input  logic [FLIT_W-1:0]        in_data,
    output logic [NUM_VC-1:0]        route_req,
    output logic [NUM_VC-1:0]        va_req,
    input  logic                     grant_valid,
    input  logic [VC_W-1:0]          grant_vc,
    input  logic [PORT_W-1:0]        grant_port,
    input  logic [VC_W-1:0]          grant_ovc,
    input  logic [NUM_VC-1:0]        pop,
    output logic [NUM_VC-1:0]        front_valid,
    output logic [NUM_VC-1:0]        front_head,
    output logic [NUM_VC-1:0]        front_tail,
    output logic [NUM_VC*FLIT_W-1:0] front_data,
    output logic [2*NUM_VC-1:0]      vc_state,
    output logic [NUM_VC*PORT_W-1:0] out_port,
    output logic [NUM_VC*VC_W-1:0]   out_ovc,
    output logic                     err_nonhead,
    output logic                     err_overflow
);
    logic [NUM_VC-1:0] lane_wr;
    logic [NUM_VC-1:0] lane_grant;
    logic [NUM_VC-1:0] lane_nonhead;
    logic [NUM_VC-1:0] lane_ovf;

    for (genvar v = 0; v < NUM_VC; v++) begin : g_lane
        vc_state_e lane_state;

        // Channel select for arriving flits and grants.
        always_comb begin
            lane_wr[v]    = in_valid && (in_vc == VC_W'(v));
            lane_grant[v] = grant_valid && (grant_vc == VC_W'(v));
        end

        vcc_lane #(
            .FLIT_W (FLIT_W),
            .DEPTH  (BUF_DEPTH),
            .AGE_W  (AGE_W),
            .PORT_W (PORT_W),
            .VC_W   (VC_W)
        ) u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .route_dly   (cfg_route_dly),
            .alloc_dly   (cfg_alloc_dly),
            .wr_en       (lane_wr[v]),
            .wr_head     (in_head),
            .wr_tail     (in_tail),
            .wr_data     (in_data),
            .pop_req     (pop[v]),
            .grant_hit   (lane_grant[v]),
            .grant_port  (grant_port),
            .grant_ovc   (grant_ovc),
            .front_valid (front_valid[v]),
            .front_head  (front_head[v]),
            .front_tail  (front_tail[v]),
            .front_data  (front_data[v*FLIT_W +: FLIT_W]),
            .state       (lane_state),
            .route_req   (route_req[v]),
            .va_req      (va_req[v]),
            .out_port    (out_port[v*PORT_W +: PORT_W]),
            .out_ovc     (out_ovc[v*VC_W +: VC_W]),
            .nonhead_evt (lane_nonhead[v]),
            .ovf_evt     (lane_ovf[v])
        );

        assign vc_state[2*v +: 2] = lane_state;
    end

    // Sticky protocol-error flags, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_nonhead  <= 1'b0;
            err_overflow <= 1'b0;
        end else begin
            err_nonhead  <= err_nonhead  | (|lane_nonhead);
            err_overflow <= err_overflow | (|lane_ovf);
        end
    end

endmodule

// File: rtl/vcc_checker.sv
// Protocol checker for vc_input_ctrl, attached by bind below.
// Assumes: sees only the top-level ports of the controller.
module vcc_checker #(
    parameter int NUM_VC = 4,
    parameter int VC_W   = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2*NUM_VC-1:0] vc_state,
    input logic [NUM_VC-1:0]   route_req,
    input logic [NUM_VC-1:0]   va_req,
    input logic [NUM_VC-1:0]   front_valid,
    input logic [NUM_VC-1:0]   front_head,
    input logic [NUM_VC-1:0]   front_tail,
    input logic [NUM_VC-1:0]   pop,
    input logic                grant_valid,
    input logic [VC_W-1:0]     grant_vc,
    input logic                err_nonhead,
    input logic                err_overflow
);
    for (genvar v = 0; v < NUM_VC; v++) begin : g_chk
        AST_ROUTE_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            route_req[v] |-> (vc_state[2*v +: 2] == 2'd0) && front_valid[v] && front_head[v]); // R3
        AST_ROUTE_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
            route_req[v] |=> (vc_state[2*v +: 2] == 2'd1)); // R3
        AST_REQ_IN_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
            va_req[v] |-> (vc_state[2*v +: 2] == 2'd2)); // R6
        AST_GRANT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
            (grant_valid && grant_vc == VC_W'(v) && va_req[v]) |=> (vc_state[2*v +: 2] == 2'd3)); // R7
        AST_TAIL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            (pop[v] && front_valid[v] && front_tail[v] && vc_state[2*v +: 2] == 2'd3)
            |=> (vc_state[2*v +: 2] == 2'd0)); // R8
        AST_NONHEAD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            (vc_state[2*v +: 2] == 2'd0 && front_valid[v] && !front_head[v]) |=> err_nonhead); // R4
    end

    AST_NONHEAD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_nonhead |=> err_nonhead); // R9
    AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_overflow |=> err_overflow); // R9

endmodule

bind vc_input_ctrl vcc_checker #(
    .NUM_VC (NUM_VC),
    .VC_W   (VC_W)
) u_vcc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .vc_state     (vc_state),
    .route_req    (route_req),
    .va_req       (va_req),
    .front_valid  (front_valid),
    .front_head   (front_head),
    .front_tail   (front_tail),
    .pop          (pop),
    .grant_valid  (grant_valid),
    .grant_vc     (grant_vc),
    .err_nonhead  (err_nonhead),
    .err_overflow (err_overflow)
);

// File: tb/test_vc_input_ctrl.sv
// Scoreboard bench: the driver queues every flit expected to be stored; the
// monitor compares each flit the switch pops against the queue front.
module test_vc_input_ctrl;
    localparam int NUM_VC = 4;
    localparam int DEPTH  = 4;
    localparam int FW     = 16;
    localparam int PW     = 3;
    localparam int AW     = 4;
    localparam int VW     = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [AW-1:0]     cfg_route_dly = '0;
    logic [AW-1:0]     cfg_alloc_dly = '0;
    logic              in_valid = 1'b0;
    logic [VW-1:0]     in_vc = '0;
    logic              in_head = 1'b0;
    logic              in_tail = 1'b0;
    logic [FW-1:0]     in_data = '0;
    logic [NUM_VC-1:0] route_req;
    logic [NUM_VC-1:0] va_req;
    logic              grant_valid = 1'b0;
    logic [VW-1:0]     grant_vc = '0;
    logic [PW-1:0]     grant_port = '0;
    logic [VW-1:0]     grant_ovc = '0;
    logic [NUM_VC-1:0] pop = '0;
    logic [NUM_VC-1:0] front_valid;
    logic [NUM_VC-1:0] front_head;
    logic [NUM_VC-1:0] front_tail;
    logic [NUM_VC*FW-1:0] front_data;
    logic [2*NUM_VC-1:0]  vc_state;
    logic [NUM_VC*PW-1:0] out_port;
    logic [NUM_VC*VW-1:0] out_ovc;
    logic              err_nonhead;
    logic              err_overflow;

    int nchecks = 0;
    int nerrors = 0;
    bit done = 1'b0;
    logic [FW+1:0] expq [NUM_VC][$];
    logic [FW+1:0] exp_e;

    always #10 clk = ~clk;

    vc_input_ctrl #(
        .NUM_VC (NUM_VC), .BUF_DEPTH (DEPTH), .FLIT_W (FW), .PORT_W (PW), .AGE_W (AW)
    ) i_vc_input_ctrl (
        .clk (clk), .rst_n (rst_n),
        .cfg_route_dly (cfg_route_dly), .cfg_alloc_dly (cfg_alloc_dly),
        .in_valid (in_valid), .in_vc (in_vc), .in_head (in_head),
        .in_tail (in_tail), .in_data (in_data),
        .route_req (route_req), .va_req (va_req),
        .grant_valid (grant_valid), .grant_vc (grant_vc),
        .grant_port (grant_port), .grant_ovc (grant_ovc),
        .pop (pop), .front_valid (front_valid), .front_head (front_head),
        .front_tail (front_tail), .front_data (front_data),
        .vc_state (vc_state), .out_port (out_port), .out_ovc (out_ovc),
        .err_nonhead (err_nonhead), .err_overflow (err_overflow)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (!ok) begin
            nerrors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] st(input int v);
        return vc_state[2*v +: 2];
    endfunction

    // Move just past the next rising edge; inputs change here.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Move to the falling edge; direct checks sample here.
    task automatic at_neg();
        @(negedge clk);
    endtask

    // Drive one flit for the coming edge; queue it if it should be stored.
    task automatic drive_flit(input int v, input bit h, input bit t, input logic [FW-1:0] d, input bit keep);
        in_valid = 1'b1;
        in_vc    = VW'(v);
        in_head  = h;
        in_tail  = t;
        in_data  = d;
        if (keep) expq[v].push_back({h, t, d});
    endtask

    // Monitor: every accepted pop is compared against the scoreboard (R2).
    always @(negedge clk) begin
        if (rst_n) begin
            for (int v = 0; v < NUM_VC; v++) begin
                if (pop[v] && vc_state[2*v +: 2] == 2'd3 && front_valid[v]) begin
                    if (expq[v].size() == 0) begin
                        chk(1'b0, "R2 unexpected flit", 32'(front_data[v*FW +: FW]), 32'h0);
                    end else begin
                        exp_e = expq[v].pop_front();
                        chk({front_head[v], front_tail[v], front_data[v*FW +: FW]} == exp_e,
                            "R2 popped flit order", 32'({front_head[v], front_tail[v], front_data[v*FW +: FW]}),
                            32'(exp_e));
                    end
                end
            end
        end
    end

    // Watchdog: a hung run is counted as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchecks++;
            nerrors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        at_neg();
        // R1: reset state
        chk(vc_state == '0, "R1 states idle", 32'(vc_state), 32'h0);
        chk(front_valid == '0, "R1 buffers empty", 32'(front_valid), 32'h0);
        chk(route_req == '0 && va_req == '0, "R1 no requests", 32'({route_req, va_req}), 32'h0);
        chk(!err_nonhead && !err_overflow, "R1 flags clear", 32'({err_nonhead, err_overflow}), 32'h0);

        // Packet on channel 1, routing delay 2, allocation delay 1.
        cfg_route_dly = 4'd2;
        cfg_alloc_dly = 4'd1;
        tick(); drive_flit(1, 1'b1, 1'b0, 16'hA001, 1'b1);
        tick(); drive_flit(1, 1'b0, 1'b0, 16'hA002, 1'b1);
        at_neg();
        chk(route_req == 4'b0010, "R3 route strobe", 32'(route_req), 32'h2);
        chk(st(1) == 2'd0, "R3 still idle with request", 32'(st(1)), 32'h0);
        chk(front_data[FW +: FW] == 16'hA001 && front_head[1], "R2 front flit", 32'(front_data[FW +: FW]), 32'hA001);
        tick(); drive_flit(1, 1'b0, 1'b1, 16'hA003, 1'b1);
        at_neg();
        chk(st(1) == 2'd1, "R3 routing entered", 32'(st(1)), 32'h1);
        chk(route_req == '0, "R3 strobe single cycle", 32'(route_req), 32'h0);
        tick(); in_valid = 1'b0; pop[1] = 1'b1;
        at_neg();
        chk(st(1) == 2'd1, "R5 routing cycle 2", 32'(st(1)), 32'h1);
        tick();
        at_neg();
        chk(st(1) == 2'd1, "R5 routing cycle 3", 32'(st(1)), 32'h1);
        chk(front_valid[1] && front_data[FW +: FW] == 16'hA001, "R2 pop ignored while routing",
            32'(front_data[FW +: FW]), 32'hA001);
        tick(); pop[1] = 1'b0;
        // Premature grant: va_req still low in this cycle.
        grant_valid = 1'b1; grant_vc = 2'd1; grant_port = 3'd6; grant_ovc = 2'd3;
        at_neg();
        chk(st(1) == 2'd2, "R5 allocation after route delay", 32'(st(1)), 32'h2);
        chk(va_req[1] == 1'b0, "R6 no request before alloc delay", 32'(va_req), 32'h0);
        tick();
        grant_port = 3'd5; grant_ovc = 2'd2;
        at_neg();
        chk(st(1) == 2'd2, "R7 early grant ignored", 32'(st(1)), 32'h2);
        chk(va_req == 4'b0010, "R6 request after alloc delay", 32'(va_req), 32'h2);
        tick(); grant_valid = 1'b0; pop[1] = 1'b1;
        at_neg();
        chk(st(1) == 2'd3, "R7 active after grant", 32'(st(1)), 32'h3);
        chk(out_port[PW +: PW] == 3'd5 && out_ovc[VW +: VW] == 2'd2, "R7 stored port and vc",
            32'({out_port[PW +: PW], out_ovc[VW +: VW]}), 32'h16);
        tick(); tick(); tick(); pop[1] = 1'b0;
        at_neg();
        chk(st(1) == 2'd0, "R8 idle after tail", 32'(st(1)), 32'h0);
        chk(expq[1].size() == 0, "R2 all channel 1 flits popped", 32'(expq[1].size()), 32'h0);

        // Non-head flit at an idle channel 2.
        tick(); drive_flit(2, 1'b0, 1'b1, 16'hBAD0, 1'b0);
        tick(); in_valid = 1'b0;
        at_neg();
        chk(!err_nonhead, "R4 flag not yet set", 32'(err_nonhead), 32'h0);
        tick();
        at_neg();
        chk(err_nonhead, "R4 flag set", 32'(err_nonhead), 32'h1);
        chk(!front_valid[2] && st(2) == 2'd0, "R4 flit dropped, idle", 32'({front_valid[2], st(2)}), 32'h0);

        // Overflow on channel 3 with zero delays.
        cfg_route_dly = 4'd0;
        cfg_alloc_dly = 4'd0;
        tick(); drive_flit(3, 1'b1, 1'b0, 16'hC001, 1'b1);
        tick(); drive_flit(3, 1'b0, 1'b0, 16'hC002, 1'b1);
        tick(); drive_flit(3, 1'b0, 1'b0, 16'hC003, 1'b1);
        at_neg();
        chk(st(3) == 2'd1, "R5 zero delay routing", 32'(st(3)), 32'h1);
        tick(); drive_flit(3, 1'b0, 1'b0, 16'hC004, 1'b1);
        at_neg();
        chk(st(3) == 2'd2 && va_req[3], "R6 zero delay request", 32'({st(3), va_req[3]}), 32'h5);
        tick(); drive_flit(3, 1'b0, 1'b1, 16'hC005, 1'b0);
        at_neg();
        chk(!err_overflow, "R9 no overflow at depth", 32'(err_overflow), 32'h0);
        tick(); in_valid = 1'b0;
        grant_valid = 1'b1; grant_vc = 2'd3; grant_port = 3'd1; grant_ovc = 2'd0;
        at_neg();
        chk(err_overflow, "R9 overflow flagged", 32'(err_overflow), 32'h1);
        tick(); grant_valid = 1'b0; pop[3] = 1'b1;
        at_neg();
        chk(st(3) == 2'd3 && out_port[3*PW +: PW] == 3'd1, "R7 channel 3 active", 32'(st(3)), 32'h3);
        repeat (5) tick();
        pop[3] = 1'b0;
        at_neg();
        chk(!front_valid[3], "R9 extra write discarded", 32'(front_valid[3]), 32'h0);
        chk(st(3) == 2'd3, "R8 no tail keeps active", 32'(st(3)), 32'h3);
        chk(expq[3].size() == 0, "R2 all channel 3 flits popped", 32'(expq[3].size()), 32'h0);
        chk(err_nonhead && err_overflow, "R9 flags sticky", 32'({err_nonhead, err_overflow}), 32'h3);
        chk(st(1) == 2'd0 && st(2) == 2'd0, "R10 other channels idle code", 32'(vc_state), 32'hC0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
        $finish;
    end

endmodule